// File: doc/BRIEF.md
# UART FIFO Control and Receive Trigger

This block is the buffering and FIFO-control slice of a 16550-style UART channel. It holds one transmit queue and one receive queue, each with its own read pointer, write pointer and occupancy counter. Software programs it through a single write-only control byte. That byte turns both queues on or off, flushes either queue on its own, picks DMA signalling and chooses one of four receive thresholds.

The serial side of the channel talks to the queues through push and pop ports. The transmit shifter pops from the transmit queue, and the receive shifter pushes into the receive queue. The block raises a receive-data interrupt request while the receive occupancy is at or above the chosen threshold. It also supplies the two-bit FIFO-enable field that the channel's interrupt status byte carries in its top bits.

Top module: `uart_fifo_ctl`

## Requirements
- R1: After reset the queues are off, DMA mode is 0, the threshold select is 00 (level 1), both levels are 0, the status pair is 00 and the interrupt request is low.
- R2: A control write with bit 0 = 1 turns the queues on, loads DMA mode from bit 3 and the threshold select from bits 7:6, all visible the cycle after the write. The status pair reads 11 while the queues are on and 00 while they are off.
- R3: A control write with bit 0 = 0 turns the queues off and empties both of them. DMA mode and the threshold select keep their earlier values whatever the other bits hold.
- R4: A control write with bits 0 and 1 both set empties the receive queue and clears its overrun flag, and leaves the transmit queue unchanged. Bit 1 is not stored, so a later write without it flushes nothing.
- R5: A control write with bits 0 and 2 both set empties the transmit queue and clears its overrun flag, and leaves the receive queue unchanged. Bit 2 is not stored either.
- R6: Threshold select 00, 01, 10 and 11 gives a level of 1, 4, 8 and 14. The interrupt request is high exactly when the queues are on and the receive level is at or above that level. It drops in the cycle after a pop takes the level below it.
- R7: Each queue returns bytes in the order they were pushed. The level rises by one per accepted push and falls by one per accepted pop. A popped byte appears on the read-data output the cycle after the pop.
- R8: A push into a full queue (16 entries) is discarded, the level stays at 16, and that queue's overrun flag is set. The flag stays set until that queue is flushed or the queues are turned off.
- R9: A pop from an empty queue leaves the read-data output holding its previous value and the level at 0.
- R10: While the queues are off, pushes and pops are ignored and both levels stay 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wr | input | 1 | Control-byte write strobe |
| cfg_wdata | input | 8 | Control byte |
| tx_push | input | 1 | Push into transmit queue |
| tx_pdata | input | 8 | Byte to push into transmit queue |
| tx_pop | input | 1 | Pop from transmit queue |
| tx_rdata | output | 8 | Last byte popped from transmit queue |
| tx_level | output | 5 | Transmit occupancy |
| tx_ovr | output | 1 | Transmit overrun flag |
| rx_push | input | 1 | Push into receive queue |
| rx_pdata | input | 8 | Byte to push into receive queue |
| rx_pop | input | 1 | Pop from receive queue |
| rx_rdata | output | 8 | Last byte popped from receive queue |
| rx_level | output | 5 | Receive occupancy |
| rx_ovr | output | 1 | Receive overrun flag |
| rx_irq | output | 1 | Receive-data interrupt request |
| rx_trig_lvl | output | 5 | Active receive threshold |
| fifo_en | output | 1 | Queues enabled |
| dma_mode | output | 1 | DMA mode select |
| isr_fifo_bits | output | 2 | FIFO-enable field for interrupt status bits 7:6 |

## Verification
The assertions assume the inputs are sampled only at rising clock edges and that push, pop and control-write strobes are single-cycle requests with no handshake. They also assume a flush or disable in the same cycle as a push or pop takes priority, which is why the overflow and empty-pop properties exclude that cycle. The stimulus changes every input on the falling edge and raises one strobe per task. The only overlaps it creates are the ones a requirement is about, so each property sees the clean cases it was written for.

// File: rtl/uart_fifo_pkg.sv
package uart_fifo_pkg;

  typedef struct packed {
    logic       en;
    logic       dma;
    logic [1:0] trig;
  } fifo_cfg_t;

  // Threshold select to receive level: 1, 4, 8, 14
  function automatic logic [4:0] trig_level(input logic [1:0] sel);
    logic [4:0] lvl;
    case (sel)
      2'b00:   lvl = 5'd1;
      2'b01:   lvl = 5'd4;
      2'b10:   lvl = 5'd8;
      default: lvl = 5'd14;
    endcase
    return lvl;
  endfunction

endpackage

// File: rtl/uart_fifo_cfg.sv
module uart_fifo_cfg
  import uart_fifo_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr,
  input  logic [7:0]      wdata,
  output fifo_cfg_t       cfg,
  output logic            rx_clr,
  output logic            tx_clr
);

  // Named write events
  logic wr_on, wr_off;
  logic unused_rsvd;

  assign wr_on       = wr &  wdata[0];
  assign wr_off      = wr & ~wdata[0];
  assign unused_rsvd = ^wdata[5:4];

  // Flush pulses are never stored: they last only for the write cycle
  assign rx_clr = wr_off | (wr_on & wdata[1]);
  assign tx_clr = wr_off | (wr_on & wdata[2]);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg <= '0;
    end else if (wr_on) begin
      cfg.en   <= 1'b1;
      cfg.dma  <= wdata[3];
      cfg.trig <= wdata[7:6];
    end else if (wr_off) begin
      cfg.en <= 1'b0;
    end
  end

  assert_enable_loads_R2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_on |=> cfg.en && (cfg.dma == $past(wdata[3])) && (cfg.trig == $past(wdata[7:6])));

  assert_disable_keeps_mode_R3: assert property (@(posedge clk) disable iff (!rst_n)
    wr_off |=> !cfg.en && $stable(cfg.dma) && $stable(cfg.trig));

endmodule

// File: rtl/uart_fifo_buf.sv
module uart_fifo_buf #(
  parameter int DW    = 8,
  parameter int DEPTH = 16,
  parameter int AW    = $clog2(DEPTH),
  parameter int LW    = AW + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic          clr,
  input  logic          push,
  input  logic [DW-1:0] pdata,
  input  logic          pop,
  output logic [DW-1:0] rdata,
  output logic [LW-1:0] level,
  output logic          ovr
);

  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] wp, rp;

  // Named events for the properties
  logic full, empty, push_ok, pop_ok, push_drop;

  assign full      = (level == LW'(DEPTH));
  assign empty     = (level == '0);
  assign push_ok   = en & push & ~full;
  assign pop_ok    = en & pop & ~empty;
  assign push_drop = en & push & full;

  always_ff @(posedge clk) begin
    if (push_ok && !clr) mem[wp] <= pdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp    <= '0;
      rp    <= '0;
      level <= '0;
      ovr   <= 1'b0;
      rdata <= '0;
    end else if (clr) begin
      wp    <= '0;
      rp    <= '0;
      level <= '0;
      ovr   <= 1'b0;
    end else begin
      if (push_ok) wp <= wp + AW'(1);
      if (pop_ok) begin
        rp    <= rp + AW'(1);
        rdata <= mem[rp];
      end
      level <= level + LW'(push_ok) - LW'(pop_ok);
      if (push_drop) ovr <= 1'b1;
    end
  end

  assert_level_bound_R7: assert property (@(posedge clk) disable iff (!rst_n)
    level <= LW'(DEPTH));

  assert_no_overflow_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (push_drop && !pop_ok && !clr) |=> (level == $past(level)) && ovr);

  assert_empty_pop_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (en && pop && empty && !push && !clr) |=> $stable(rdata) && (level == '0));

  assert_flush_empties_R4: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (level == '0) && !ovr);

  assert_idle_when_off_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!en && !clr) |=> $stable(level) && $stable(rdata));

endmodule

// File: rtl/uart_fifo_ctl.sv
module uart_fifo_ctl
  import uart_fifo_pkg::*;
#(
  parameter int DW    = 8,
  parameter int DEPTH = 16,
  parameter int LVL_W = $clog2(DEPTH) + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_wr,
  input  logic [7:0]       cfg_wdata,
  input  logic             tx_push,
  input  logic [DW-1:0]    tx_pdata,
  input  logic             tx_pop,
  output logic [DW-1:0]    tx_rdata,
  output logic [LVL_W-1:0] tx_level,
  output logic             tx_ovr,
  input  logic             rx_push,
  input  logic [DW-1:0]    rx_pdata,
  input  logic             rx_pop,
  output logic [DW-1:0]    rx_rdata,
  output logic [LVL_W-1:0] rx_level,
  output logic             rx_ovr,
  output logic             rx_irq,
  output logic [LVL_W-1:0] rx_trig_lvl,
  output logic             fifo_en,
  output logic             dma_mode,
  output logic [1:0]       isr_fifo_bits
);

  fifo_cfg_t cfg;
  logic      rx_clr, tx_clr;

  uart_fifo_cfg u_cfg (
    .clk   (clk),
    .rst_n (rst_n),
    .wr    (cfg_wr),
    .wdata (cfg_wdata),
    .cfg   (cfg),
    .rx_clr(rx_clr),
    .tx_clr(tx_clr)
  );

  uart_fifo_buf #(.DW(DW), .DEPTH(DEPTH), .LW(LVL_W)) u_txq (
    .clk(clk), .rst_n(rst_n), .en(cfg.en), .clr(tx_clr),
    .push(tx_push), .pdata(tx_pdata), .pop(tx_pop),
    .rdata(tx_rdata), .level(tx_level), .ovr(tx_ovr)
  );

  uart_fifo_buf #(.DW(DW), .DEPTH(DEPTH), .LW(LVL_W)) u_rxq (
    .clk(clk), .rst_n(rst_n), .en(cfg.en), .clr(rx_clr),
    .push(rx_push), .pdata(rx_pdata), .pop(rx_pop),
    .rdata(rx_rdata), .level(rx_level), .ovr(rx_ovr)
  );

  assign rx_trig_lvl   = LVL_W'(trig_level(cfg.trig));
  assign rx_irq        = cfg.en && (rx_level >= rx_trig_lvl);
  assign fifo_en       = cfg.en;
  assign dma_mode      = cfg.dma;
  assign isr_fifo_bits = {2{cfg.en}};

  assert_irq_drop_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_irq && rx_pop && !rx_push && !cfg_wr && (rx_level == rx_trig_lvl)) |=> !rx_irq);

  assert_status_pair_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (isr_fifo_bits == 2'b11) || (isr_fifo_bits == 2'b00));

endmodule

// File: tb/uart_fifo_ctl_tb.sv
module uart_fifo_ctl_tb;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cfg_wr = 1'b0;
  logic [7:0] cfg_wdata = '0;
  logic       tx_push = 1'b0, tx_pop = 1'b0, rx_push = 1'b0, rx_pop = 1'b0;
  logic [7:0] tx_pdata = '0, rx_pdata = '0;
  logic [7:0] tx_rdata, rx_rdata;
  logic [4:0] tx_level, rx_level, rx_trig_lvl;
  logic       tx_ovr, rx_ovr, rx_irq, fifo_en, dma_mode;
  logic [1:0] isr_fifo_bits;

  int checks = 0;
  int fails  = 0;

  always #10 clk = ~clk;

  uart_fifo_ctl u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_wdata(cfg_wdata),
    .tx_push(tx_push), .tx_pdata(tx_pdata), .tx_pop(tx_pop),
    .tx_rdata(tx_rdata), .tx_level(tx_level), .tx_ovr(tx_ovr),
    .rx_push(rx_push), .rx_pdata(rx_pdata), .rx_pop(rx_pop),
    .rx_rdata(rx_rdata), .rx_level(rx_level), .rx_ovr(rx_ovr),
    .rx_irq(rx_irq), .rx_trig_lvl(rx_trig_lvl), .fifo_en(fifo_en),
    .dma_mode(dma_mode), .isr_fifo_bits(isr_fifo_bits)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  // All strobes rise on a falling edge and fall on the next one
  task automatic wr_cfg(input logic [7:0] d);
    @(negedge clk); cfg_wr = 1'b1; cfg_wdata = d;
    @(negedge clk); cfg_wr = 1'b0;
  endtask

  task automatic push_rx(input logic [7:0] d);
    @(negedge clk); rx_push = 1'b1; rx_pdata = d;
    @(negedge clk); rx_push = 1'b0;
  endtask

  task automatic push_tx(input logic [7:0] d);
    @(negedge clk); tx_push = 1'b1; tx_pdata = d;
    @(negedge clk); tx_push = 1'b0;
  endtask

  task automatic pop_rx();
    @(negedge clk); rx_pop = 1'b1;
    @(negedge clk); rx_pop = 1'b0;
  endtask

  task automatic pop_tx();
    @(negedge clk); tx_pop = 1'b1;
    @(negedge clk); tx_pop = 1'b0;
  endtask

  task automatic t_reset();
    chk("R1 fifo_en", fifo_en, 0);
    chk("R1 dma_mode", dma_mode, 0);
    chk("R1 trig", rx_trig_lvl, 1);
    chk("R1 rx_level", rx_level, 0);
    chk("R1 tx_level", tx_level, 0);
    chk("R1 status", isr_fifo_bits, 0);
    chk("R1 irq", rx_irq, 0);
  endtask

  task automatic t_enable();
    wr_cfg(8'h01);
    chk("R2 fifo_en", fifo_en, 1);
    chk("R2 status", isr_fifo_bits, 3);
    chk("R2 dma_mode", dma_mode, 0);
  endtask

  task automatic t_order();
    logic [7:0] vals [3] = '{8'hA5, 8'h3C, 8'hF0};
    for (int i = 0; i < 3; i++) push_tx(vals[i]);
    chk("R7 tx_level after pushes", tx_level, 3);
    for (int i = 0; i < 3; i++) begin
      pop_tx();
      chk("R7 tx order", tx_rdata, vals[i]);
      chk("R7 tx_level after pop", tx_level, 2 - i);
    end
  endtask

  task automatic t_trigger();
    int lv [4] = '{1, 4, 8, 14};
    for (int s = 0; s < 4; s++) begin
      wr_cfg(8'(s << 6) | 8'h03);
      chk("R6 trig level", rx_trig_lvl, lv[s]);
      chk("R6 irq empty", rx_irq, 0);
      for (int k = 0; k < lv[s] - 1; k++) push_rx(8'(k));
      chk("R6 irq below", rx_irq, 0);
      push_rx(8'h77);
      chk("R6 irq at level", rx_irq, 1);
      pop_rx();
      chk("R6 irq drops", rx_irq, 0);
    end
  endtask

  task automatic t_full();
    wr_cfg(8'h03);
    for (int i = 0; i < 17; i++) push_rx(8'(i + 16));
    chk("R8 level capped", rx_level, 16);
    chk("R8 overrun", rx_ovr, 1);
    for (int i = 0; i < 16; i++) begin
      pop_rx();
      chk("R7 rx order", rx_rdata, i + 16);
    end
    chk("R8 overrun sticky", rx_ovr, 1);
    pop_rx();
    chk("R9 rdata held", rx_rdata, 31);
    chk("R9 level zero", rx_level, 0);
    wr_cfg(8'h03);
    chk("R8 overrun cleared by flush", rx_ovr, 0);
  endtask

  task automatic t_flush();
    wr_cfg(8'h07);
    push_tx(8'h11); push_tx(8'h22); push_tx(8'h33);
    push_rx(8'h44); push_rx(8'h55);
    wr_cfg(8'h03);
    chk("R4 rx flushed", rx_level, 0);
    chk("R4 tx untouched", tx_level, 3);
    wr_cfg(8'h01);
    chk("R4 bit not stored", tx_level, 3);
    push_rx(8'h66);
    wr_cfg(8'h01);
    chk("R4 rx not reflushed", rx_level, 1);
    wr_cfg(8'h05);
    chk("R5 tx flushed", tx_level, 0);
    chk("R5 rx untouched", rx_level, 1);
    pop_rx();
    chk("R5 rx data intact", rx_rdata, 8'h66);
  endtask

  task automatic t_disable();
    logic [7:0] held;
    wr_cfg(8'hC9);
    chk("R2 dma loaded", dma_mode, 1);
    chk("R2 trig loaded", rx_trig_lvl, 14);
    push_rx(8'h12); push_rx(8'h34); push_tx(8'h56);
    held = rx_rdata;
    wr_cfg(8'h00);
    chk("R3 disabled", fifo_en, 0);
    chk("R2 status off", isr_fifo_bits, 0);
    chk("R3 dma kept", dma_mode, 1);
    chk("R3 trig kept", rx_trig_lvl, 14);
    chk("R3 rx emptied", rx_level, 0);
    chk("R3 tx emptied", tx_level, 0);
    wr_cfg(8'h86);
    chk("R3 dma kept again", dma_mode, 1);
    chk("R3 trig kept again", rx_trig_lvl, 14);
    push_rx(8'h9A); push_tx(8'hBC);
    chk("R10 rx push ignored", rx_level, 0);
    chk("R10 tx push ignored", tx_level, 0);
    chk("R10 irq off", rx_irq, 0);
    pop_rx();
    chk("R10 rx pop ignored", rx_rdata, held);
    wr_cfg(8'h01);
    chk("R3 restart empty", rx_level, 0);
    chk("R2 re-enabled", fifo_en, 1);
    chk("R2 dma reloaded", dma_mode, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=timeout expected=done");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_enable();
    t_order();
    t_trigger();
    t_full();
    t_flush();
    t_disable();
    finish_run();
  end

endmodule